// File: doc/BRIEF.md
# Three-phase sine PWM generator

This block turns a rotor position into six raw switch requests for a three-phase inverter bridge. It takes a sector index (0 to 5) with a 5-bit position inside the sector, a 5-bit lead-angle code, a pair of limit codes that bound the lead angle, a 5-bit digitized voltage command and a conduction-mode select. An internal 6-bit triangular carrier runs up and down with a period of 252 clocks. Each phase compares a sine-shaped reference, scaled by the voltage command, against this shared carrier to decide when its high-side and low-side switches are requested.

With a very small voltage command the block stops modulating. It then requests only the three low-side switches, in short pulses that keep bootstrap supplies charged. In 120-degree mode each phase is released in two of its six sectors. The outputs feed a separate dead-time stage.

Top module: `spwm_gen`

## Requirements
- R1: While rst_n is low, all six outputs are 0. After release the carrier starts at 0 and counts upward.
- R2: The carrier steps 0,1,...,63,62,...,1,0,... and holds each value for exactly two clocks, so one period is 252 clocks.
- R3: The effective lead is lead_min when lead_min > lead_max. Otherwise it is lead_code limited to the range lead_min..lead_max.
- R4: The reference is 32+m in the first half of a phase revolution and 32-m in the second, where m = floor(A*vcmd/32), A = round(31*|sin(k*7.5 deg)|) and k = floor(phase angle/4). A high side is on when its reference is greater than the carrier. In 180-degree mode (mode180=1) the matching low side is its complement.
- R5: Phase U's angle is (32*sector + sub_pos + lead) mod 192, in steps of 1.875 deg. Phase V adds 128 and phase W adds 64, both mod 192. Bit 0 of hi_o/lo_o is U, bit 1 is V and bit 2 is W.
- R6: With mode180=0, a phase whose own sector (phase angle/32) is 2 or 5 has both outputs off. In its other sectors it behaves as in R4.
- R7: When vcmd < 8 (refresh), every high side is off and every low side is on exactly while the carrier is below 6, which is 22 of 252 clocks. When vcmd >= 8, R4 and R6 apply.
- R8: The outputs are registered. They reflect the inputs and the carrier value present at the previous clock edge.
- R9: Sector codes 6 and 7 are accepted and wrap through the mod-192 angle of R5.
- R10: The high and low outputs of one phase are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector | input | 3 | Rotor sector index |
| sub_pos | input | 5 | Position inside the sector |
| lead_code | input | 5 | Requested lead-angle code |
| lead_min | input | 5 | Lower limit for the lead code |
| lead_max | input | 5 | Upper limit for the lead code |
| vcmd | input | 5 | Digitized voltage command |
| mode180 | input | 1 | 1: 180-degree conduction, 0: 120-degree conduction |
| hi_o | output | 3 | High-side requests, bit 0 U, bit 1 V, bit 2 W |
| lo_o | output | 3 | Low-side requests, bit 0 U, bit 1 V, bit 2 W |

## Verification
The bench builds the block with its default parameters: a 6-bit carrier, 32 positions per sector, a 5-bit voltage command, a refresh threshold of 8 and a refresh pulse width of 6. At these sizes one carrier period is only 252 clocks, and a sweep of all 192 angles takes a few hundred clocks. Every angle can therefore be paired with many carrier values. The refresh pulse count can be taken over a whole period, and the wrap of sector codes 6 and 7 can be exercised directly.

// File: rtl/spwm_gen.sv
module spwm_gen #(
  parameter int CW = 6,
  parameter int LW = 5,
  parameter int VW = 5,
  parameter int RFSH_LVL = 8,
  parameter int RFSH_ON = 6
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sector,
  input  logic [LW-1:0] sub_pos,
  input  logic [LW-1:0] lead_code,
  input  logic [LW-1:0] lead_min,
  input  logic [LW-1:0] lead_max,
  input  logic [VW-1:0] vcmd,
  input  logic          mode180,
  output logic [2:0]    hi_o,
  output logic [2:0]    lo_o
);
  localparam int AW    = LW + 4;
  localparam int STEPS = 6 << LW;
  localparam int SH    = LW - 3;
  localparam int MID   = 1 << (CW - 1);
  localparam logic [CW-1:0] CMAX = '1;

  function automatic logic [4:0] qsin(input logic [3:0] r);
    case (r)
      4'd0:  qsin = 5'd0;
      4'd1:  qsin = 5'd4;
      4'd2:  qsin = 5'd8;
      4'd3:  qsin = 5'd12;
      4'd4:  qsin = 5'd16;
      4'd5:  qsin = 5'd19;
      4'd6:  qsin = 5'd22;
      4'd7:  qsin = 5'd25;
      4'd8:  qsin = 5'd27;
      4'd9:  qsin = 5'd29;
      4'd10: qsin = 5'd30;
      default: qsin = 5'd31;
    endcase
  endfunction

  logic [CW-1:0] car_q;
  logic half_q, up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q  <= '0;
      half_q <= 1'b0;
      up_q   <= 1'b1;
    end else begin
      half_q <= ~half_q;
      if (half_q) begin
        if (up_q) begin
          car_q <= car_q + 1'b1;
          if (car_q == CMAX - 1'b1) up_q <= 1'b0;
        end else begin
          car_q <= car_q - 1'b1;
          if (car_q == CW'(1)) up_q <= 1'b1;
        end
      end
    end
  end

  logic [LW-1:0] lead_eff;
  logic [AW-1:0] raw, base;
  logic refresh;

  assign lead_eff = (lead_min > lead_max || lead_code < lead_min) ? lead_min :
                    (lead_code > lead_max) ? lead_max : lead_code;
  assign raw      = AW'({sector, sub_pos}) + AW'(lead_eff);
  assign base     = (raw >= AW'(STEPS)) ? raw - AW'(STEPS) : raw;
  assign refresh  = vcmd < VW'(RFSH_LVL);

  logic [2:0] hi_d, lo_d;

  for (genvar p = 0; p < 3; p++) begin : g_ph
    localparam int OFS = ((3 - p) % 3) * (STEPS / 3);
    logic [AW-1:0] sum, ang;
    logic [5:0]    k;
    logic [3:0]    r;
    logic [1:0]    quad;
    logic [4:0]    amp;
    logic [VW+4:0] prod;
    logic [CW-1:0] mag, ref_v;
    logic          conduct, above;

    assign sum = base + AW'(OFS);
    assign ang = (sum >= AW'(STEPS)) ? sum - AW'(STEPS) : sum;
    assign k   = 6'(ang >> SH);

    always_comb begin
      if (k < 6'd12)      begin quad = 2'd0; r = 4'(k); end
      else if (k < 6'd24) begin quad = 2'd1; r = 4'(k - 6'd12); end
      else if (k < 6'd36) begin quad = 2'd2; r = 4'(k - 6'd24); end
      else                begin quad = 2'd3; r = 4'(k - 6'd36); end
    end

    assign amp     = quad[0] ? qsin(4'd12 - r) : qsin(r);
    assign prod    = amp * vcmd;
    assign mag     = CW'(prod >> VW);
    assign ref_v   = quad[1] ? CW'(MID) - mag : CW'(MID) + mag;
    assign above   = ref_v > car_q;
    assign conduct = mode180 || ((ang >> LW) != AW'(2) && (ang >> LW) != AW'(5));
    assign hi_d[p] = !refresh && conduct && above;
    assign lo_d[p] = refresh ? (car_q < CW'(RFSH_ON)) : (conduct && !above);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= '0;
      lo_o <= '0;
    end else begin
      hi_o <= hi_d;
      lo_o <= lo_d;
    end
  end
endmodule

// File: rtl/spwm_gen_chk.sv
module spwm_gen_chk #(
  parameter int CW = 6,
  parameter int VW = 5,
  parameter int RFSH_LVL = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] vcmd,
  input logic          mode180,
  input logic [CW-1:0] car_q,
  input logic [2:0]    hi_o,
  input logic [2:0]    lo_o
);
  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_o & lo_o) == 3'b000); // R10

  AST_FULL_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (vcmd >= VW'(RFSH_LVL) && mode180) |=> ((hi_o ^ lo_o) == 3'b111)); // R4

  AST_RFSH_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (vcmd < VW'(RFSH_LVL)) |=> (hi_o == 3'b000)); // R7

  AST_RFSH_LO_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (vcmd < VW'(RFSH_LVL)) |=> (lo_o == 3'b000 || lo_o == 3'b111)); // R7

  AST_CAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (car_q == $past(car_q)) || (car_q == $past(car_q) + 1'b1) ||
    (car_q == $past(car_q) - 1'b1)); // R2

  AST_CAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (car_q != $past(car_q)) |=> $stable(car_q)); // R2
endmodule

bind spwm_gen spwm_gen_chk #(.CW(CW), .VW(VW), .RFSH_LVL(RFSH_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .vcmd(vcmd), .mode180(mode180),
  .car_q(car_q), .hi_o(hi_o), .lo_o(lo_o));

// File: tb/spwm_gen_tb.sv
`timescale 1ns/1ps
module spwm_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sector = '0;
  logic [4:0] sub_pos = '0, lead_code = '0, lead_min = '0, lead_max = 5'd31, vcmd = 5'd31;
  logic mode180 = 1'b1;
  logic [2:0] hi_o, lo_o;

  spwm_gen u_dut (.clk(clk), .rst_n(rst_n), .sector(sector), .sub_pos(sub_pos),
    .lead_code(lead_code), .lead_min(lead_min), .lead_max(lead_max),
    .vcmd(vcmd), .mode180(mode180), .hi_o(hi_o), .lo_o(lo_o));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int mc = 0, mph = 0, mup = 1;
  logic [2:0] ehi = '0, elo = '0;
  logic chk_en = 1'b0;
  string tag = "R1";

  function automatic int ref_of(int pa, int v);
    int k, amp, m;
    real s;
    k = pa / 4;
    s = $sin(k * 7.5 * 3.14159265358979 / 180.0);
    if (s < 0.0) s = -s;
    amp = $rtoi(s * 31.0 + 0.5 + 1.0e-9);
    m = (amp * v) / 32;
    return (k >= 24) ? 32 - m : 32 + m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; mph = 0; mup = 1; ehi = '0; elo = '0;
    end else begin
      int le, a, pa, rv, ps;
      le = (lead_min > lead_max || lead_code < lead_min) ? int'(lead_min) :
           (lead_code > lead_max) ? int'(lead_max) : int'(lead_code);
      a = (32 * int'(sector) + int'(sub_pos) + le) % 192;
      for (int p = 0; p < 3; p++) begin
        pa = (a + ((p == 0) ? 0 : (p == 1) ? 128 : 64)) % 192;
        ps = pa / 32;
        if (vcmd < 5'd8) begin
          ehi[p] = 1'b0;
          elo[p] = (mc < 6);
        end else if (!mode180 && (ps == 2 || ps == 5)) begin
          ehi[p] = 1'b0;
          elo[p] = 1'b0;
        end else begin
          rv = ref_of(pa, int'(vcmd));
          ehi[p] = (rv > mc);
          elo[p] = !(rv > mc);
        end
      end
      if (mph == 1) begin
        if (mup == 1) begin mc++; if (mc == 63) mup = 0; end
        else begin mc--; if (mc == 0) mup = 1; end
      end
      mph = 1 - mph;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (hi_o !== ehi || lo_o !== elo) begin
        fails++;
        $display("FAIL %s hi=%b lo=%b expected hi=%b lo=%b", tag, hi_o, lo_o, ehi, elo);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic sweep(int stp, int hold, string t);
    tag = t;
    for (int a = 0; a < 192; a += stp) begin
      sector = 3'(a / 32);
      sub_pos = 5'(a % 32);
      repeat (hold) @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (hi_o !== 3'b000 || lo_o !== 3'b000) begin
        fails++;
        $display("FAIL R1 hi=%b lo=%b expected hi=000 lo=000", hi_o, lo_o);
      end
    end
    rst_n = 1'b1;
    chk_en = 1'b1;
    sweep(1, 3, "R4 R5 R8 R10 full amplitude");
    vcmd = 5'd16; lead_code = 5'd31;
    sweep(1, 2, "R4 R5 half amplitude max lead");
    lead_code = 5'd20; lead_min = 5'd5; lead_max = 5'd12;
    sweep(3, 5, "R3 code above upper limit");
    lead_code = 5'd3; lead_min = 5'd20; lead_max = 5'd10;
    sweep(3, 5, "R3 lower limit above upper");
    lead_min = 5'd0; lead_max = 5'd31; lead_code = 5'd7; vcmd = 5'd31; mode180 = 1'b0;
    sweep(1, 3, "R6 120 degree mode");
    mode180 = 1'b1; vcmd = 5'd8;
    sweep(2, 4, "R7 threshold not refresh");
    tag = "R9 sector wrap";
    for (int s = 6; s < 8; s++) begin
      for (int b = 0; b < 32; b += 4) begin
        sector = 3'(s); sub_pos = 5'(b);
        repeat (6) @(negedge clk);
      end
    end
    vcmd = 5'd7; tag = "R7 refresh";
    repeat (300) @(negedge clk);
    begin
      int on = 0;
      for (int i = 0; i < 252; i++) begin
        @(negedge clk);
        if (lo_o[0]) on++;
      end
      checks++;
      if (on != 22) begin
        fails++;
        $display("FAIL R2 refresh low-side on count=%0d expected=22", on);
      end
    end
    vcmd = 5'd0; mode180 = 1'b0;
    sweep(4, 3, "R7 zero command");
    chk_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule